// File: doc/BRIEF.md
# External Interrupt Flag Detector

This block watches a set of asynchronous, active-low interrupt pins and keeps one pending flag per pin. Each pin has its own trigger-type bit. With the type bit at 1 the pin is falling-edge triggered: a high-to-low transition latches the pending flag, which stays set until the interrupt is acknowledged. With the type bit at 0 the pin is low-level triggered: the pending flag reports the inverted synchronised pin on every cycle.

Pins pass through a multi-flop synchroniser before detection. Software changes the type and flag bits one bit at a time. A single bit-operation port selects a field (type or flag) and a channel index, and either sets or clears that bit. The flags and type bits are shown continuously on plain status outputs. No pin carries a data stream, so the block has no valid/ready handshake. All pins are plain control and status.

Top module: `eiq_flag_detector`

## Requirements
- R1: After reset every type bit is 0 (level mode) and every pending flag is 0 while the pins are high.
- R2: With the default two synchroniser stages, a pin change applied before a rising clock edge reaches the pending flag on the third rising edge from then, and not earlier.
- R3: In edge mode (type 1) the flag is set when the synchronised pin was 1 in the previous sample and is 0 in the current one. A rising edge or a pin held steady does not set it.
- R4: In edge mode a set flag holds until an acknowledge pulse on its channel, which clears it on the next edge.
- R5: In edge mode a falling edge detected in the same cycle as an acknowledge leaves the flag set.
- R6: In level mode (type 0) the flag equals the inverse of the synchronised pin every cycle, and an acknowledge has no lasting effect.
- R7: A bit operation with field 0 targets the type bit and field 1 targets the flag bit of the channel given by the index. Value 1 sets the bit and value 0 clears it. No other bit changes.
- R8: In edge mode a flag write takes priority over an acknowledge in the same cycle, and a detected falling edge takes priority over a flag clear in the same cycle.
- R9: In level mode a flag write has no effect; the flag keeps following the pin.
- R10: Channels are independent: a pin, acknowledge or write on one channel does not change another channel's flag or type.
- R11: A bit operation whose index is not below the channel count changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous interrupt pins, active low |
| ack_i | input | NUM_CH | Per-channel acknowledge pulse |
| bit_we_i | input | 1 | Perform a bit operation this cycle |
| bit_field_i | input | 1 | 0 selects the type bit, 1 selects the flag bit |
| bit_idx_i | input | IDX_W | Channel index of the bit operation |
| bit_val_i | input | 1 | 1 sets the selected bit, 0 clears it |
| trig_type_o | output | NUM_CH | Current type bits (1 = falling edge) |
| pend_o | output | NUM_CH | Pending flags |

## Verification
The bench builds the block with three channels and the default two synchroniser stages. Three channels make the index field two bits wide, so index 3 is an out-of-range operation that the bench can drive to check R11. The third channel also lets the bench set one channel up as an edge trigger while the others stay in level mode or stay idle, and confirm that they do not disturb each other. Two stages fix the pin-to-flag latency at three edges, and the bench samples at exactly that point and one cycle before it.

// File: rtl/eiq_pkg.sv
package eiq_pkg;
  typedef enum logic {
    FIELD_TYPE = 1'b0,
    FIELD_FLAG = 1'b1
  } bit_field_e;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;
endpackage

// File: rtl/eiq_sync.sv
module eiq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '1;
          else         stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '1;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];
endmodule

// File: rtl/eiq_bit_decode.sv
module eiq_bit_decode
  import eiq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              field_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [NUM_CH-1:0] wr_type_o,
  output logic [NUM_CH-1:0] wr_flag_o
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign wr_type_o[c] = we_i && (field_i == FIELD_TYPE) && (int'(idx_i) == c);
      assign wr_flag_o[c] = we_i && (field_i == FIELD_FLAG) && (int'(idx_i) == c);
    end
  endgenerate

  AST_ONE_BIT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_type_o, wr_flag_o})); // R7

  AST_RANGE_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx_i) >= NUM_CH) |-> ({wr_type_o, wr_flag_o} == '0)); // R11
endmodule

// File: rtl/eiq_channel.sv
module eiq_channel
  import eiq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic ack_i,
  input  logic wr_type_i,
  input  logic wr_flag_i,
  input  logic wr_val_i,
  output logic trig_o,
  output logic pend_o
);
  trig_e trig_q;
  logic  prev_q;
  logic  flag_q;
  logic  flag_d;
  logic  fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        trig_q <= TRIG_LEVEL;
    else if (wr_type_i) trig_q <= trig_e'(wr_val_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_i;
  end

  assign fall = prev_q & ~sync_i;

  always_comb begin
    flag_d = flag_q;
    if (trig_q == TRIG_LEVEL) begin
      flag_d = ~sync_i;
    end else begin
      if (ack_i)     flag_d = 1'b0;
      if (wr_flag_i) flag_d = wr_val_i;
      if (fall)      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign trig_o = (trig_q == TRIG_FALL);
  assign pend_o = flag_q;

  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q == TRIG_FALL && fall) |=> pend_o); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q == TRIG_FALL && ack_i && !fall && !wr_flag_i) |=> !pend_o); // R4

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q == TRIG_FALL && !ack_i && !fall && !wr_flag_i) |=> $stable(pend_o)); // R3

  AST_LEVEL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q == TRIG_LEVEL) |=> (pend_o == !$past(sync_i))); // R6

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q == TRIG_FALL && wr_flag_i && !fall) |=> (pend_o == $past(wr_val_i))); // R8
endmodule

// File: rtl/eiq_flag_detector.sv
module eiq_flag_detector
  import eiq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_CH-1:0] ack_i,
  input  logic              bit_we_i,
  input  logic              bit_field_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  output logic [NUM_CH-1:0] trig_type_o,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] wr_type;
  logic [NUM_CH-1:0] wr_flag;

  eiq_sync #(
    .WIDTH  (NUM_CH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  eiq_bit_decode #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bit_we_i),
    .field_i   (bit_field_i),
    .idx_i     (bit_idx_i),
    .wr_type_o (wr_type),
    .wr_flag_o (wr_flag)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      eiq_channel u_ch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sync_i    (pin_sync[c]),
        .ack_i     (ack_i[c]),
        .wr_type_i (wr_type[c]),
        .wr_flag_i (wr_flag[c]),
        .wr_val_i  (bit_val_i),
        .trig_o    (trig_type_o[c]),
        .pend_o    (pend_o[c])
      );
    end
  endgenerate

  AST_TYPE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_we_i && bit_field_i == FIELD_TYPE && int'(bit_idx_i) < NUM_CH)
    |=> (trig_type_o[$past(bit_idx_i)] == $past(bit_val_i))); // R7

  AST_TYPE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_we_i && bit_field_i == FIELD_TYPE && int'(bit_idx_i) < NUM_CH)
    |=> $stable(trig_type_o)); // R10
endmodule

// File: tb/eiq_flag_detector_tb_top.sv
module eiq_flag_detector_tb_top;
  localparam int NC = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] pin;
  logic [NC-1:0] ack;
  logic          wr_en;
  logic          wr_field;
  logic [IW-1:0] wr_idx;
  logic          wr_val;
  logic [NC-1:0] type_o;
  logic [NC-1:0] flag_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  eiq_flag_detector #(.NUM_CH(NC), .SYNC_STAGES(2)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .ack_i       (ack),
    .bit_we_i    (wr_en),
    .bit_field_i (wr_field),
    .bit_idx_i   (wr_idx),
    .bit_val_i   (wr_val),
    .trig_type_o (type_o),
    .pend_o      (flag_o)
  );

  task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic f, input logic [IW-1:0] i, input logic v);
    wr_en = 1'b1; wr_field = f; wr_idx = i; wr_val = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack(input logic [NC-1:0] m);
    ack = m;
    @(negedge clk);
    ack = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin = '1; ack = '0; wr_en = 1'b0; wr_field = 1'b0; wr_idx = '0; wr_val = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    chk("R1 type after reset", type_o, 3'b000);
    chk("R1 flag after reset", flag_o, 3'b000);
    wait_n(2);
    chk("R1 flag idle level", flag_o, 3'b000);
  endtask

  task automatic t_level;
    pin[1] = 1'b0;
    wait_n(2);
    chk("R2 level not yet", flag_o, 3'b000);
    wait_n(1);
    chk("R2 R6 level low flags", flag_o, 3'b010);
    pulse_ack(3'b010);
    chk("R6 ack ignored in level", flag_o, 3'b010);
    pin[1] = 1'b1;
    wait_n(3);
    chk("R6 level released", flag_o, 3'b000);
  endtask

  task automatic t_edge;
    do_wr(1'b0, 2'd0, 1'b1);
    chk("R7 type set ch0", type_o, 3'b001);
    pin[0] = 1'b0;
    wait_n(2);
    chk("R2 edge not yet", flag_o, 3'b000);
    wait_n(1);
    chk("R3 fall sets", flag_o, 3'b001);
    pin[0] = 1'b1;
    wait_n(4);
    chk("R4 hold through rise", flag_o, 3'b001);
    pulse_ack(3'b001);
    chk("R4 ack clears", flag_o, 3'b000);
    pin[0] = 1'b0;
    wait_n(3);
    pulse_ack(3'b001);
    wait_n(4);
    chk("R3 steady low no retrigger", flag_o, 3'b000);
    pin[0] = 1'b1;
    wait_n(3);
  endtask

  task automatic t_collide;
    do_wr(1'b1, 2'd0, 1'b1);
    chk("R8 flag write set", flag_o, 3'b001);
    pin[0] = 1'b0;
    wait_n(2);
    pulse_ack(3'b001);
    chk("R5 fall beats ack", flag_o, 3'b001);
    pulse_ack(3'b001);
    chk("R4 ack after collide", flag_o, 3'b000);
    pin[0] = 1'b1;
    wait_n(3);
    ack = 3'b001;
    do_wr(1'b1, 2'd0, 1'b1);
    ack = '0;
    chk("R8 write beats ack", flag_o, 3'b001);
    pin[0] = 1'b0;
    wait_n(2);
    do_wr(1'b1, 2'd0, 1'b0);
    chk("R8 fall beats clear", flag_o, 3'b001);
    do_wr(1'b1, 2'd0, 1'b0);
    chk("R7 flag write clear", flag_o, 3'b000);
    pin[0] = 1'b1;
    wait_n(3);
  endtask

  task automatic t_level_write;
    do_wr(1'b1, 2'd1, 1'b1);
    chk("R9 level write ignored", flag_o, 3'b000);
    wait_n(1);
    chk("R9 level write no later effect", flag_o, 3'b000);
  endtask

  task automatic t_range;
    do_wr(1'b0, 2'd3, 1'b1);
    chk("R11 out of range type", type_o, 3'b001);
    do_wr(1'b1, 2'd3, 1'b1);
    chk("R11 out of range flag", flag_o, 3'b000);
  endtask

  task automatic t_indep;
    do_wr(1'b0, 2'd2, 1'b1);
    chk("R10 type ch2 only", type_o, 3'b101);
    pin[2] = 1'b0;
    wait_n(3);
    chk("R10 only ch2 flags", flag_o, 3'b100);
    pulse_ack(3'b001);
    chk("R10 ack ch0 leaves ch2", flag_o, 3'b100);
    pulse_ack(3'b100);
    chk("R10 ack ch2 clears", flag_o, 3'b000);
    do_wr(1'b0, 2'd0, 1'b0);
    chk("R7 type clear ch0", type_o, 3'b100);
    pin[2] = 1'b1;
    wait_n(3);
    chk("R10 ch0 level idle", flag_o, 3'b000);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_collide();
    t_level_write();
    t_range();
    t_indep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule